// File: doc/BRIEF.md
# Indirect Configuration Table Access Controller

This block is a register slave that guards three internal configuration tables: a scheme table (32 entries of 23 words), a port binding table (64 entries of two words) and a small classification-plan table (16 single-word entries). None of these entries is mapped on the bus. Software reaches them only through a shared window of 23 staging registers and a single action register. To write an entry, software fills the staging words and then writes a command with the GO bit set. To read an entry, it issues a read command and collects the staging words once GO has cleared.

A command word carries the transfer direction, the target table, the entry index and the word selection. While a transfer runs, GO reads back as 1. The block moves one word slot per clock and clears GO by itself when it finishes, so software polls the action register. A command that names an entry that does not exist, or uses the unused target code, moves nothing. Such a command raises the command-error bit and leaves a copy of itself in a capture register. The block also holds a plain configuration register and a two-bit error event register, whose bits are set by hardware event pulses and cleared by writing 1.

Top module: `cfg_table_access`

## Requirements
- R1: After synchronous reset, the configuration, event, capture and action registers and every staging word all read 0, and GO is clear.
- R2: The action register is at 0x1FC. Its fields are: bit 31 GO, bit 30 direction (1 = table to staging, 0 = staging to table), bit 29 command error, bits 25:24 target (00 scheme, 01 classification plan, 10 port, 11 invalid), bits 23:16 scheme index, and bits 7:0 port or plan index. A scheme write stores staging words 0x100..0x158 into the entry, and a later read of that entry returns them to the same staging offsets.
- R3: GO reads 1 for exactly as many cycles after the accepting clock edge as the command has word slots: 23 for a scheme command, 2 for a port command, and 1 for a plan command or a failing command. It then reads 0.
- R4: For a scheme write, the entry's counter word (staging offset 0x140) is stored only when bit 15 is set. With bit 15 clear, the entry keeps its old counter word.
- R5: For port commands, bit 15 selects the scheme-partition word (staging 0x100) and bit 14 selects the plan-partition word (staging 0x104). A word that is not selected is left unchanged in the table on a write and in staging on a read.
- R6: A plan command moves one word between staging offset 0x100 and the indexed plan entry.
- R7: A command with scheme index ≥ 32, port index ≥ 64, plan index ≥ 16 or target 11 changes no entry. It sets bit 29 of the action register and loads the capture register (0x02C) with the command word with bit 29 set. The next accepted action write clears bit 29.
- R8: While GO is set, writes to the action register and to the staging window are ignored.
- R9: The configuration register at 0x000 is a 32-bit read/write register. Bit 31 is the enable bit.
- R10: In the event register at 0x00C, bit 31 is set by a double-ECC pulse and bit 30 by a key-size overflow pulse. Writing 1 to a bit clears it, but a set in the same cycle wins over the clear. The other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 9 | Byte address of the register being accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ecc_dbl_err | input | 1 | Double-ECC event pulse |
| key_size_ovf | input | 1 | Key-size overflow event pulse |

## Verification
The tests cover full-entry scheme writes with and without the counter-update bit, each followed by a read-back over a staging window that has been refilled with a different pattern. This separates real table storage from stale staging contents, and separates an updated counter word from a preserved one. Port commands are issued with each word-select bit alone and with both together, which shows that each select steers exactly one word in each direction. Out-of-range indices are chosen so that they would alias a live entry if truncated, so any leak into the tables shows up. Writes to the action register and the window during a transfer, and event sets that coincide with clears, exercise the ordering rules.

// File: rtl/cta_pkg.sv
package cta_pkg;
    localparam int DATA_W       = 32;
    localparam int ADDR_W       = 9;
    localparam int SCH_WORDS    = 23;
    localparam int SCH_CNT_SLOT = 16;
    localparam int SLOT_W       = $clog2(SCH_WORDS);

    localparam logic [ADDR_W-1:0] A_CFG     = 9'h000;
    localparam logic [ADDR_W-1:0] A_EVT     = 9'h00C;
    localparam logic [ADDR_W-1:0] A_CAP     = 9'h02C;
    localparam logic [ADDR_W-1:0] A_WIN     = 9'h100;
    localparam logic [ADDR_W-1:0] A_ACT     = 9'h1FC;
    localparam logic [ADDR_W-1:0] A_WIN_END = A_WIN + ADDR_W'(4 * SCH_WORDS);

    localparam int B_GO  = 31;
    localparam int B_RD  = 30;
    localparam int B_ERR = 29;

    typedef enum logic [1:0] {
        TGT_SCH  = 2'b00,
        TGT_CLS  = 2'b01,
        TGT_PORT = 2'b10,
        TGT_BAD  = 2'b11
    } tgt_e;

    typedef struct packed {
        logic       rd;
        tgt_e       tgt;
        logic [7:0] idx;
        logic       sel_a;   // bit 15: SP word / counter update
        logic       sel_b;   // bit 14: plan-partition word
    } cmd_t;

    function automatic cmd_t cmd_decode(input logic [DATA_W-1:0] w);
        cmd_t c;
        c.rd    = w[B_RD];
        c.tgt   = tgt_e'(w[25:24]);
        c.idx   = (c.tgt == TGT_SCH) ? w[23:16] : w[7:0];
        c.sel_a = w[15];
        c.sel_b = w[14];
        return c;
    endfunction
endpackage

// File: rtl/cta_cmd_check.sv
module cta_cmd_check
    import cta_pkg::*;
#(
    parameter int N_SCH  = 32,
    parameter int N_PORT = 64,
    parameter int N_CLS  = 16
) (
    input  cmd_t              cmd,
    output logic              bad,
    output logic [SLOT_W-1:0] n_slots
);
    localparam logic [8:0] LIM_SCH  = 9'(N_SCH);
    localparam logic [8:0] LIM_PORT = 9'(N_PORT);
    localparam logic [8:0] LIM_CLS  = 9'(N_CLS);
    localparam logic [SLOT_W-1:0] NS_SCH  = SLOT_W'(SCH_WORDS);
    localparam logic [SLOT_W-1:0] NS_PORT = SLOT_W'(2);
    localparam logic [SLOT_W-1:0] NS_ONE  = SLOT_W'(1);

    wire unused_sel = cmd.rd ^ cmd.sel_a ^ cmd.sel_b;

    always_comb begin
        case (cmd.tgt)
            TGT_SCH:  bad = ({1'b0, cmd.idx} >= LIM_SCH);
            TGT_PORT: bad = ({1'b0, cmd.idx} >= LIM_PORT);
            TGT_CLS:  bad = ({1'b0, cmd.idx} >= LIM_CLS);
            default:  bad = 1'b1;
        endcase
        if (bad)                       n_slots = NS_ONE;
        else if (cmd.tgt == TGT_SCH)   n_slots = NS_SCH;
        else if (cmd.tgt == TGT_PORT)  n_slots = NS_PORT;
        else                           n_slots = NS_ONE;
    end
endmodule

// File: rtl/cta_seq.sv
module cta_seq
    import cta_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [SLOT_W-1:0] n_slots,
    output logic              busy,
    output logic [SLOT_W-1:0] slot,
    output logic              last
);
    assign last = busy && (slot == n_slots - SLOT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            slot <= '0;
        end else if (start) begin
            busy <= 1'b1;
            slot <= '0;
        end else if (busy) begin
            if (last) begin
                busy <= 1'b0;
                slot <= '0;
            end else begin
                slot <= slot + SLOT_W'(1);
            end
        end
    end
endmodule

// File: rtl/cta_tables.sv
module cta_tables
    import cta_pkg::*;
#(
    parameter int N_SCH  = 32,
    parameter int N_PORT = 64,
    parameter int N_CLS  = 16
) (
    input  logic              clk,
    input  logic              active,
    input  cmd_t              cmd,
    input  logic [SLOT_W-1:0] slot,
    input  logic [DATA_W-1:0] wr_word,
    output logic              ld_en,
    output logic [DATA_W-1:0] ld_word
);
    localparam int SI_W = $clog2(N_SCH);
    localparam int PI_W = $clog2(N_PORT);
    localparam int CI_W = $clog2(N_CLS);
    localparam logic [SLOT_W-1:0] CNT_SLOT = SLOT_W'(SCH_CNT_SLOT);

    logic [DATA_W-1:0] sch_mem  [N_SCH][SCH_WORDS];
    logic [DATA_W-1:0] port_sp  [N_PORT];
    logic [DATA_W-1:0] port_cpp [N_PORT];
    logic [DATA_W-1:0] cls_mem  [N_CLS];

    wire [SI_W-1:0] si = cmd.idx[SI_W-1:0];
    wire [PI_W-1:0] pi = cmd.idx[PI_W-1:0];
    wire [CI_W-1:0] ci = cmd.idx[CI_W-1:0];
    wire unused_idx = ^cmd.idx;
    wire slot0 = (slot == '0);
    wire slot1 = (slot == SLOT_W'(1));

    always_ff @(posedge clk) begin
        if (active && !cmd.rd) begin
            case (cmd.tgt)
                TGT_SCH:
                    if (slot != CNT_SLOT || cmd.sel_a) sch_mem[si][slot] <= wr_word;
                TGT_PORT: begin
                    if (slot0 && cmd.sel_a) port_sp[pi]  <= wr_word;
                    if (slot1 && cmd.sel_b) port_cpp[pi] <= wr_word;
                end
                TGT_CLS: cls_mem[ci] <= wr_word;
                default: ;
            endcase
        end
    end

    always_comb begin
        ld_en   = 1'b0;
        ld_word = '0;
        if (active && cmd.rd) begin
            case (cmd.tgt)
                TGT_SCH: begin
                    ld_en   = 1'b1;
                    ld_word = sch_mem[si][slot];
                end
                TGT_PORT: begin
                    ld_en   = (slot0 && cmd.sel_a) || (slot1 && cmd.sel_b);
                    ld_word = slot0 ? port_sp[pi] : port_cpp[pi];
                end
                TGT_CLS: begin
                    ld_en   = 1'b1;
                    ld_word = cls_mem[ci];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cfg_table_access.sv
module cfg_table_access
    import cta_pkg::*;
#(
    parameter int N_SCHEMES = 32,
    parameter int N_PORTS   = 64,
    parameter int N_CLS     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ecc_dbl_err,
    input  logic              key_size_ovf
);
    logic [DATA_W-1:0] cfg_q, cap_q, act_q;
    logic [1:0]        evt_q;
    logic              err_q;
    logic [SCH_WORDS-1:0][DATA_W-1:0] stage_q;

    cmd_t              cmd;
    logic              bad, busy, last, ld_en;
    logic [SLOT_W-1:0] n_slots, slot, win_idx;
    logic [DATA_W-1:0] ld_word;
    logic [ADDR_W-1:0] win_off;
    logic              wr_act, start, win_hit;

    assign cmd     = cmd_decode(act_q);
    assign wr_act  = bus_wr && (bus_addr == A_ACT);
    assign start   = wr_act && !busy && bus_wdata[B_GO];
    assign win_off = bus_addr - A_WIN;
    assign win_idx = win_off[SLOT_W+1:2];
    assign win_hit = (bus_addr >= A_WIN) && (bus_addr < A_WIN_END) && (bus_addr[1:0] == 2'b00);

    cta_cmd_check #(.N_SCH(N_SCHEMES), .N_PORT(N_PORTS), .N_CLS(N_CLS)) u_check (
        .cmd(cmd), .bad(bad), .n_slots(n_slots)
    );

    cta_seq u_seq (
        .clk(clk), .rst(rst), .start(start), .n_slots(n_slots),
        .busy(busy), .slot(slot), .last(last)
    );

    cta_tables #(.N_SCH(N_SCHEMES), .N_PORT(N_PORTS), .N_CLS(N_CLS)) u_tables (
        .clk(clk), .active(busy && !bad), .cmd(cmd), .slot(slot),
        .wr_word(stage_q[slot]), .ld_en(ld_en), .ld_word(ld_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            evt_q <= '0;
            cap_q <= '0;
            act_q <= '0;
            err_q <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == A_CFG) cfg_q <= bus_wdata;
            evt_q <= (evt_q & ~((bus_wr && bus_addr == A_EVT) ? bus_wdata[31:30] : 2'b00))
                     | {ecc_dbl_err, key_size_ovf};
            if (wr_act && !busy) begin
                act_q <= bus_wdata;
                err_q <= 1'b0;
            end
            if (last && bad) begin
                err_q <= 1'b1;
                cap_q <= act_q | (DATA_W'(1) << B_ERR);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                            stage_q <= '0;
        else if (!busy && bus_wr && win_hit) stage_q[win_idx] <= bus_wdata;
        else if (ld_en)                     stage_q[slot] <= ld_word;
    end

    always_comb begin
        bus_rdata = '0;
        if (win_hit) bus_rdata = stage_q[win_idx];
        else begin
            case (bus_addr)
                A_CFG:   bus_rdata = cfg_q;
                A_EVT:   bus_rdata = {evt_q, 30'b0};
                A_CAP:   bus_rdata = cap_q;
                A_ACT:   bus_rdata = {busy, act_q[B_RD], err_q, act_q[28:0]};
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/cta_checker.sv
module cta_checker
    import cta_pkg::*;
(
    input logic                             clk,
    input logic                             rst,
    input logic                             busy,
    input logic                             rd_cmd,
    input logic                             err,
    input logic [SCH_WORDS*DATA_W-1:0]      stage,
    input logic [DATA_W-1:0]                act,
    input logic [1:0]                       evt,
    input logic                             ecc,
    input logic                             kov
);
    logic [7:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy)         busy_cnt <= '0;
        else if (busy_cnt != '1)  busy_cnt <= busy_cnt + 8'd1;
    end

    p_reset_idle_r1: assert property (@(posedge clk) rst |=> (!busy && !err));

    p_go_bounded_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_cnt < 8'(SCH_WORDS)));

    p_err_at_end_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> $fell(busy));

    p_stage_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !rd_cmd) |=> $stable(stage));

    p_act_hold_r8: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(act));

    p_ecc_set_r10: assert property (@(posedge clk) disable iff (rst)
        ecc |=> evt[1]);

    p_kov_set_r10: assert property (@(posedge clk) disable iff (rst)
        kov |=> evt[0]);
endmodule

bind cfg_table_access cta_checker u_chk (
    .clk(clk), .rst(rst), .busy(busy), .rd_cmd(cmd.rd), .err(err_q),
    .stage(stage_q), .act(act_q), .evt(evt_q), .ecc(ecc_dbl_err), .kov(key_size_ovf)
);

// File: tb/cfg_table_access_test.sv
module cfg_table_access_test;
    localparam int NS = 32, NP = 64, NC = 16, NW = 23;
    localparam logic [8:0] CFG = 9'h000, EVT = 9'h00C, CAP = 9'h02C, WIN = 9'h100, ACT = 9'h1FC;

    logic        clk = 1'b0, rst = 1'b1, bus_wr = 1'b0, ecc = 1'b0, kov = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;

    always #10 clk = ~clk;

    cfg_table_access #(.N_SCHEMES(NS), .N_PORTS(NP), .N_CLS(NC)) uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ecc_dbl_err(ecc), .key_size_ovf(kov)
    );

    int checks = 0, errors = 0, cyc = 0;

    // behavioural reference model
    logic [31:0] m_cfg, m_cap, m_act;
    logic [1:0]  m_evt;
    logic        m_err, m_busy;
    int          m_slot;
    logic [31:0] m_stage [NW];
    logic [31:0] m_sch [NS][NW];
    logic [31:0] m_sp [NP], m_cpp [NP], m_cls [NC];

    function automatic int m_idx(logic [31:0] w);
        return (w[25:24] == 2'b00) ? int'(w[23:16]) : int'(w[7:0]);
    endfunction

    function automatic bit m_bad(logic [31:0] w);
        int t = int'(w[25:24]);
        int i = m_idx(w);
        return t == 3 || (t == 0 && i >= NS) || (t == 2 && i >= NP) || (t == 1 && i >= NC);
    endfunction

    function automatic int m_len(logic [31:0] w);
        if (m_bad(w)) return 1;
        if (w[25:24] == 2'b00) return NW;
        if (w[25:24] == 2'b10) return 2;
        return 1;
    endfunction

    task automatic do_slot(int k);
        int i = m_idx(m_act);
        bit rd = m_act[30];
        if (m_bad(m_act)) return;
        case (int'(m_act[25:24]))
            0: if (rd) m_stage[k] = m_sch[i][k];
               else if (k != 16 || m_act[15]) m_sch[i][k] = m_stage[k];
            2: begin
                if (k == 0 && m_act[15]) begin
                    if (rd) m_stage[0] = m_sp[i]; else m_sp[i] = m_stage[0];
                end
                if (k == 1 && m_act[14]) begin
                    if (rd) m_stage[1] = m_cpp[i]; else m_cpp[i] = m_stage[1];
                end
            end
            1: if (rd) m_stage[0] = m_cls[i]; else m_cls[i] = m_stage[0];
            default: ;
        endcase
    endtask

    task automatic model_step();
        logic [1:0] clr;
        if (rst) begin
            m_cfg = 0; m_cap = 0; m_act = 0; m_evt = 0; m_err = 0; m_busy = 0; m_slot = 0;
            for (int k = 0; k < NW; k++) m_stage[k] = 0;
            return;
        end
        clr = (bus_wr && bus_addr == EVT) ? bus_wdata[31:30] : 2'b00;
        m_evt = (m_evt & ~clr) | {ecc, kov};
        if (bus_wr && bus_addr == CFG) m_cfg = bus_wdata;
        if (m_busy) begin
            do_slot(m_slot);
            if (m_slot == m_len(m_act) - 1) begin
                m_busy = 0;
                if (m_bad(m_act)) begin
                    m_err = 1;
                    m_cap = m_act | 32'h2000_0000;
                end
            end else m_slot++;
        end else begin
            if (bus_wr && bus_addr >= WIN && bus_addr < 9'h15C && bus_addr[1:0] == 2'b00)
                m_stage[int'(bus_addr - WIN) / 4] = bus_wdata;
            if (bus_wr && bus_addr == ACT) begin
                m_act = bus_wdata;
                m_err = 0;
                if (bus_wdata[31]) begin m_busy = 1; m_slot = 0; end
            end
        end
    endtask

    function automatic logic [31:0] m_read(logic [8:0] a);
        if (a >= WIN && a < 9'h15C && a[1:0] == 2'b00) return m_stage[int'(a - WIN) / 4];
        case (a)
            CFG: return m_cfg;
            EVT: return {m_evt, 30'b0};
            CAP: return m_cap;
            ACT: return {m_busy, m_act[30], m_err, m_act[28:0]};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(logic [8:0] a);
        if (a == CFG) return "R9";
        if (a == EVT) return "R10";
        if (a == CAP) return "R7";
        if (a == ACT) return "R3";
        return "R2";
    endfunction

    always @(posedge clk) begin
        logic [31:0] e;
        cyc++;
        model_step();
        #5;
        e = m_read(bus_addr);
        checks++;
        if (bus_rdata !== e) begin
            errors++;
            $display("FAIL %s model compare addr %h: actual %h expected %h",
                     tag_of(bus_addr), bus_addr, bus_rdata, e);
        end
    end

    always @(posedge clk) if (cyc > 60000) begin
        errors++;
        $display("FAIL R3 watchdog: actual cycle %0d expected completion before 60000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [8:0] a, logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(logic [8:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; #2; d = bus_rdata;
    endtask

    task automatic fill(logic [31:0] base);
        for (int k = 0; k < NW; k++) wr(WIN + 9'(4 * k), base + 32'(k));
    endtask

    task automatic run_cmd(logic [31:0] c, output int n);
        wr(ACT, c);
        #2; n = 0;
        while (bus_rdata[31] && n < 100) begin n++; @(negedge clk); #2; end
    endtask

    initial begin
        logic [31:0] d;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(CFG, d); chk("R1 cfg", d, 0);
        rd(EVT, d); chk("R1 evt", d, 0);
        rd(CAP, d); chk("R1 cap", d, 0);
        rd(ACT, d); chk("R1 action", d, 0);
        rd(WIN, d); chk("R1 staging", d, 0);
        // R9
        wr(CFG, 32'h8000_0001); rd(CFG, d); chk("R9 cfg enable", d, 32'h8000_0001);
        // R2 / R3 scheme write then read
        fill(32'hA500_0000);
        run_cmd(32'h8005_8000, n); chk("R3 scheme write length", n, 23);
        rd(ACT, d); chk("R2 action readback", d, 32'h0005_8000);
        fill(32'hB600_0000);
        run_cmd(32'hC005_0000, n); chk("R3 scheme read length", n, 23);
        rd(WIN, d);          chk("R2 word0", d, 32'hA500_0000);
        rd(WIN + 9'd64, d);  chk("R2 word16", d, 32'hA500_0010);
        rd(WIN + 9'd88, d);  chk("R2 word22", d, 32'hA500_0016);
        // R4 counter word kept
        fill(32'hC700_0000);
        run_cmd(32'h8005_0000, n);
        fill(32'hB600_0000);
        run_cmd(32'hC005_0000, n);
        rd(WIN + 9'd64, d);  chk("R4 counter kept", d, 32'hA500_0010);
        rd(WIN, d);          chk("R4 other word written", d, 32'hC700_0000);
        // R5 port words
        wr(WIN, 32'h11); wr(WIN + 9'd4, 32'h22);
        run_cmd(32'h8200_800A, n); chk("R3 port length", n, 2);
        wr(WIN, 32'h44); wr(WIN + 9'd4, 32'h33);
        run_cmd(32'h8200_400A, n);
        wr(WIN, 32'h0); wr(WIN + 9'd4, 32'h0);
        run_cmd(32'hC200_C00A, n);
        rd(WIN, d);         chk("R5 sp only from first write", d, 32'h11);
        rd(WIN + 9'd4, d);  chk("R5 cpp from second write", d, 32'h33);
        wr(WIN, 32'h99);
        run_cmd(32'hC200_400A, n);
        rd(WIN, d);         chk("R5 unselected staging kept", d, 32'h99);
        // R6 plan table
        wr(WIN, 32'h1234_5678);
        run_cmd(32'h8100_0003, n); chk("R6 plan length", n, 1);
        wr(WIN, 32'h0);
        run_cmd(32'hC100_0003, n);
        rd(WIN, d); chk("R6 plan readback", d, 32'h1234_5678);
        // R7 errors
        run_cmd(32'h8028_8000, n); chk("R7 bad scheme length", n, 1);
        rd(ACT, d); chk("R7 error bit", d, 32'h2028_8000);
        rd(CAP, d); chk("R7 capture", d, 32'hA028_8000);
        wr(WIN, 32'hDEAD);
        run_cmd(32'h8200_C04A, n);
        rd(CAP, d); chk("R7 capture port", d, 32'hA200_C04A);
        run_cmd(32'hC200_C00A, n);
        rd(WIN, d); chk("R7 no aliasing write", d, 32'h11);
        rd(ACT, d); chk("R7 error cleared", d, 32'h4200_C00A);
        run_cmd(32'h8300_0000, n);
        rd(ACT, d); chk("R7 target 11", d, 32'h2300_0000);
        // R8 writes ignored while busy
        wr(WIN, 32'h5555);
        wr(ACT, 32'h8006_8000);
        wr(ACT, 32'h8200_8001);
        wr(WIN, 32'h0BAD);
        run_cmd(32'h0006_8000, n);
        rd(ACT, d); chk("R8 action kept", d, 32'h0006_8000);
        rd(WIN, d); chk("R8 staging kept", d, 32'h5555);
        // R10 events
        @(negedge clk); ecc = 1'b1; @(negedge clk); ecc = 1'b0;
        rd(EVT, d); chk("R10 ecc set", d, 32'h8000_0000);
        @(negedge clk); kov = 1'b1; @(negedge clk); kov = 1'b0;
        rd(EVT, d); chk("R10 ovf set", d, 32'hC000_0000);
        wr(EVT, 32'h8000_0000);
        rd(EVT, d); chk("R10 w1c", d, 32'h4000_0000);
        @(negedge clk); bus_wr = 1'b1; bus_addr = EVT; bus_wdata = 32'h4000_0000; kov = 1'b1;
        @(negedge clk); bus_wr = 1'b0; kov = 1'b0;
        rd(EVT, d); chk("R10 set wins", d, 32'h4000_0000);
        wr(EVT, 32'hFFFF_FFFF);
        rd(EVT, d); chk("R10 cleared", d, 32'h0);
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule